// File: doc/BRIEF.md
# Key-Length Configuration Controller

This block decides which of three cipher configurations, one per supported key length (128, 192 and 256 bits), must be resident in a reconfigurable region. It watches a detection strobe that carries a 2-bit key-length code. When the code names a length different from the one in place, it records the new settings in its configuration outputs and raises a reconfiguration request. The settings are a partial-program index and a length code. The loading machinery answers with an acknowledge once the region holds the new configuration, and only then does the controller tell the cipher core, through a valid signal, that it may run.

The machine has four states: an idle start state entered at reset, and one resident state per key length. From any resident state a new legal length moves it directly to the matching resident state. A security monitor can raise an attack flag; its assertion edge makes the controller reload the configuration already in place, which issues a fresh request with unchanged settings. Detection strobes that repeat the active length, and those carrying the unused code, cause nothing.

Top module: `keycfg_ctrl`

## Requirements
- R1: After a synchronous reset the state output is 0 (start), the request and valid outputs are 0, and the program index and length outputs are 0.
- R2: In the start state the controller leaves only on a detection strobe with a legal code; an acknowledge or an attack edge seen there changes no output.
- R3: A legal strobe that moves the controller enters the resident state for that code: code 2'b00 (128 bits) gives state 1, 2'b01 (192 bits) gives state 2, 2'b10 (256 bits) gives state 3. State and settings take their new values at the same clock edge that raises the request.
- R4: From any resident state a legal strobe naming another length moves the controller straight to the matching resident state and issues a request with the new settings.
- R5: The request is high for exactly one cycle per accepted event, and the settings do not change in any cycle in which no request is raised.
- R6: The valid output is 0 from the edge that raises a request until the edge at which an acknowledge is sampled with no new request in the same cycle; it is also 0 in the start state. An acknowledge with no request outstanding has no effect.
- R7: A strobe carrying the length already resident raises no request and leaves valid high.
- R8: A rising edge of the attack flag in a resident state raises one request with unchanged settings and drops valid until the acknowledge; holding the flag high gives no further requests. When a legal length change and an attack edge arrive together, a single request carries the new length.
- R9: The code 2'b11 is illegal; a strobe carrying it changes no output in any state.
- R10: The program index output is 0 for the 128-bit configuration, 1 for 192 bits and 2 for 256 bits, and the length output repeats the accepted code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| det_stb | input | 1 | Key-length detection strobe |
| det_len | input | 2 | Detected length code, valid with det_stb |
| rcfg_ack | input | 1 | Reconfiguration complete |
| attack | input | 1 | Attack-detected flag |
| ctl_state | output | 2 | Current state: 0 start, 1/2/3 resident 128/192/256 |
| cfg_prog | output | 2 | Selected partial-program index |
| cfg_klen | output | 2 | Key-length code of the selected configuration |
| rcfg_req | output | 1 | One-cycle reconfiguration request |
| cfg_valid | output | 1 | Configuration loaded; enables the cipher core |

## Verification
The bench targets the handshake corners: an acknowledge arriving in the same cycle as a new request must leave valid low, and a second length change issued before the first acknowledge must keep it low. A design that let the stale acknowledge through would enable the core on a half-loaded region. It also holds the attack flag high over several cycles, where a level-sensitive design would stream requests and never settle. It sends repeated and illegal codes in both the start and resident states, where a careless decoder would issue spurious reloads or leave for a nonexistent fourth configuration.

// File: rtl/keycfg_pkg.sv
package keycfg_pkg;
    localparam int LEN_W   = 2;
    localparam int PROG_W  = 2;
    localparam int NUM_CFG = 3;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_K128  = 2'd1,
        ST_K192  = 2'd2,
        ST_K256  = 2'd3
    } kc_state_e;

    typedef struct packed {
        logic [PROG_W-1:0] prog;
        logic [LEN_W-1:0]  klen;
    } kc_cfg_t;

    // resident state for a legal length code
    function automatic kc_state_e state_of(input logic [LEN_W-1:0] code);
        return kc_state_e'(code + LEN_W'(1));
    endfunction
endpackage

// File: rtl/keycfg_decode.sv
module keycfg_decode
    import keycfg_pkg::*;
#(
    parameter int N_CFG = NUM_CFG,
    parameter int LW    = LEN_W,
    parameter int PW    = PROG_W
) (
    input  logic [LW-1:0] code,
    output logic          legal,
    output logic [PW-1:0] prog
);
    logic [N_CFG-1:0] hit;

    for (genvar g = 0; g < N_CFG; g++) begin : g_cmp
        assign hit[g] = (code == LW'(g));
    end

    always_comb begin
        prog = '0;
        for (int i = 0; i < N_CFG; i++) begin
            if (hit[i]) prog = PW'(i);
        end
    end

    assign legal = |hit;
endmodule

// File: rtl/keycfg_fsm.sv
module keycfg_fsm
    import keycfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              det_stb,
    input  logic [LEN_W-1:0]  det_len,
    input  logic              legal,
    input  logic [PROG_W-1:0] prog_in,
    input  logic              attack,
    output kc_state_e         state_q,
    output kc_state_e         state_d,
    output kc_cfg_t           cfg_q,
    output logic              req_q,
    output logic              evt
);
    kc_cfg_t cfg_d;
    logic    atk_q;
    logic    atk_rise;
    logic    change;
    logic    reload;

    always_comb begin
        atk_rise = attack && !atk_q;
        change   = det_stb && legal &&
                   ((state_q == ST_START) || (det_len != cfg_q.klen));
        reload   = atk_rise && (state_q != ST_START);
        evt      = change || reload;
        state_d  = state_q;
        cfg_d    = cfg_q;
        if (change) begin
            state_d    = state_of(det_len);
            cfg_d.prog = prog_in;
            cfg_d.klen = det_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_START;
            cfg_q   <= '0;
            req_q   <= 1'b0;
            atk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
            req_q   <= evt;
            atk_q   <= attack;
        end
    end
endmodule

// File: rtl/keycfg_hs.sv
module keycfg_hs
    import keycfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      evt,
    input  logic      ack,
    input  kc_state_e state_d,
    output logic      valid_q
);
    logic pend_q;
    logic pend_d;

    always_comb begin
        pend_d = evt || (pend_q && !ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            valid_q <= (state_d != ST_START) && !pend_d;
        end
    end
endmodule

// File: rtl/keycfg_ctrl.sv
module keycfg_ctrl
    import keycfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              det_stb,
    input  logic [LEN_W-1:0]  det_len,
    input  logic              rcfg_ack,
    input  logic              attack,
    output logic [1:0]        ctl_state,
    output logic [PROG_W-1:0] cfg_prog,
    output logic [LEN_W-1:0]  cfg_klen,
    output logic              rcfg_req,
    output logic              cfg_valid
);
    logic              legal;
    logic [PROG_W-1:0] prog_dec;
    kc_state_e         st_q;
    kc_state_e         st_d;
    kc_cfg_t           cfg;
    logic              evt;

    keycfg_decode #(.N_CFG(NUM_CFG), .LW(LEN_W), .PW(PROG_W)) u_dec (
        .code  (det_len),
        .legal (legal),
        .prog  (prog_dec)
    );

    keycfg_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .det_stb (det_stb),
        .det_len (det_len),
        .legal   (legal),
        .prog_in (prog_dec),
        .attack  (attack),
        .state_q (st_q),
        .state_d (st_d),
        .cfg_q   (cfg),
        .req_q   (rcfg_req),
        .evt     (evt)
    );

    keycfg_hs u_hs (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .ack     (rcfg_ack),
        .state_d (st_d),
        .valid_q (cfg_valid)
    );

    assign ctl_state = st_q;
    assign cfg_prog  = cfg.prog;
    assign cfg_klen  = cfg.klen;
endmodule

// File: rtl/keycfg_ctrl_chk.sv
module keycfg_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       det_stb,
    input logic [1:0] det_len,
    input logic       rcfg_ack,
    input logic       attack,
    input logic [1:0] ctl_state,
    input logic [1:0] cfg_prog,
    input logic [1:0] cfg_klen,
    input logic       rcfg_req,
    input logic       cfg_valid
);
    // R6: no enable while a request is in flight
    a_r6_valid_off_on_req: assert property (@(posedge clk) disable iff (rst)
        rcfg_req |-> !cfg_valid);

    // R6: valid only rises after an acknowledge
    a_r6_valid_needs_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid) |-> $past(rcfg_ack));

    // R5: settings hold when no request is raised
    a_r5_cfg_stable: assert property (@(posedge clk) disable iff (rst)
        !rcfg_req |-> ($stable(cfg_prog) && $stable(cfg_klen)));

    // R9: illegal code with no attack gives no request
    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        (det_stb && det_len == 2'b11 && !attack) |=> !rcfg_req);

    // R7: repeated length gives no request
    a_r7_same_quiet: assert property (@(posedge clk) disable iff (rst)
        (det_stb && ctl_state != 2'd0 && det_len == cfg_klen && !attack) |=> !rcfg_req);

    // R2: start state holds without a legal strobe
    a_r2_start_holds: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == 2'd0 && !(det_stb && det_len != 2'b11)) |=> (ctl_state == 2'd0 && !rcfg_req));

    // R10: program index follows the resident state
    a_r10_prog_map: assert property (@(posedge clk) disable iff (rst)
        (ctl_state != 2'd0) |-> (cfg_prog == ctl_state - 2'd1));
endmodule

bind keycfg_ctrl keycfg_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .det_stb   (det_stb),
    .det_len   (det_len),
    .rcfg_ack  (rcfg_ack),
    .attack    (attack),
    .ctl_state (ctl_state),
    .cfg_prog  (cfg_prog),
    .cfg_klen  (cfg_klen),
    .rcfg_req  (rcfg_req),
    .cfg_valid (cfg_valid)
);

// File: tb/keycfg_ctrl_tb_top.sv
module keycfg_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       det_stb = 1'b0;
    logic [1:0] det_len = 2'b00;
    logic       rcfg_ack = 1'b0;
    logic       attack = 1'b0;
    logic [1:0] ctl_state;
    logic [1:0] cfg_prog;
    logic [1:0] cfg_klen;
    logic       rcfg_req;
    logic       cfg_valid;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    keycfg_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .det_stb   (det_stb),
        .det_len   (det_len),
        .rcfg_ack  (rcfg_ack),
        .attack    (attack),
        .ctl_state (ctl_state),
        .cfg_prog  (cfg_prog),
        .cfg_klen  (cfg_klen),
        .rcfg_req  (rcfg_req),
        .cfg_valid (cfg_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at a falling edge, pass one rising edge, return at the next falling edge
    task automatic cyc(input logic stb, input logic [1:0] len, input logic ack, input logic atk);
        det_stb  = stb;
        det_len  = len;
        rcfg_ack = ack;
        attack   = atk;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input int st, input int prog,
                              input int req, input int vld);
        chk({tag, " state"}, ctl_state, st);
        chk({tag, " prog"},  cfg_prog, prog);
        chk({tag, " req"},   rcfg_req, req);
        chk({tag, " valid"}, cfg_valid, vld);
    endtask

    task automatic t_reset;
        expect_out("R1 reset", 0, 0, 0, 0);
        chk("R1 reset klen", cfg_klen, 0);
    endtask

    task automatic t_start_ignores;
        cyc(0, 2'b00, 1, 0);
        expect_out("R2 ack in start", 0, 0, 0, 0);
        cyc(0, 2'b00, 0, 1);
        expect_out("R2 attack in start", 0, 0, 0, 0);
        cyc(1, 2'b11, 0, 0);
        expect_out("R9 illegal in start", 0, 0, 0, 0);
    endtask

    task automatic t_enter_192;
        cyc(1, 2'b01, 0, 0);
        expect_out("R3 enter 192", 2, 1, 1, 0);
        chk("R10 klen 192", cfg_klen, 1);
        cyc(0, 2'b00, 0, 0);
        expect_out("R5 pulse ends", 2, 1, 0, 0);
        cyc(0, 2'b00, 1, 0);
        expect_out("R6 ack enables", 2, 1, 0, 1);
        cyc(0, 2'b00, 1, 0);
        expect_out("R6 stray ack", 2, 1, 0, 1);
    endtask

    task automatic t_same_len;
        cyc(1, 2'b01, 0, 0);
        expect_out("R7 same length", 2, 1, 0, 1);
    endtask

    task automatic t_change_256;
        cyc(1, 2'b10, 0, 0);
        expect_out("R4 change to 256", 3, 2, 1, 0);
        chk("R10 klen 256", cfg_klen, 2);
        cyc(0, 2'b00, 1, 0);
        expect_out("R6 ack after change", 3, 2, 0, 1);
        cyc(1, 2'b11, 0, 0);
        expect_out("R9 illegal resident", 3, 2, 0, 1);
    endtask

    task automatic t_attack_hold;
        cyc(0, 2'b00, 0, 1);
        expect_out("R8 reload", 3, 2, 1, 0);
        chk("R8 reload klen", cfg_klen, 2);
        cyc(0, 2'b00, 0, 1);
        expect_out("R8 held once", 3, 2, 0, 0);
        cyc(0, 2'b00, 1, 1);
        expect_out("R8 ack reload", 3, 2, 0, 1);
        cyc(0, 2'b00, 0, 0);
        expect_out("R8 release", 3, 2, 0, 1);
    endtask

    task automatic t_attack_with_change;
        cyc(1, 2'b00, 0, 1);
        expect_out("R8 attack+change", 1, 0, 1, 0);
        chk("R10 klen 128", cfg_klen, 0);
        cyc(0, 2'b00, 0, 0);
        expect_out("R5 single req", 1, 0, 0, 0);
        cyc(0, 2'b00, 1, 0);
        expect_out("R6 ack 128", 1, 0, 0, 1);
    endtask

    task automatic t_back_to_back;
        cyc(1, 2'b01, 0, 0);
        expect_out("R4 first change", 2, 1, 1, 0);
        cyc(1, 2'b10, 0, 0);
        expect_out("R4 second change", 3, 2, 1, 0);
        cyc(1, 2'b00, 1, 0);
        expect_out("R6 ack with new req", 1, 0, 1, 0);
        cyc(0, 2'b00, 0, 0);
        expect_out("R6 still pending", 1, 0, 0, 0);
        cyc(0, 2'b00, 1, 0);
        expect_out("R6 final ack", 1, 0, 0, 1);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_start_ignores();
        t_enter_192();
        t_same_len();
        t_change_256();
        t_attack_hold();
        t_attack_with_change();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule